// File: doc/BRIEF.md
# Multi-Width Serial Flash Target Front End

This block sits on the device side of a serial flash port and turns the pin activity driven by a host into byte-level events for the rest of the memory. Chip select, the serial clock, the pause (hold) pin and the eight I/O lines are sampled with a fast system clock. The block detects serial clock edges in that clock domain and runs one state machine for all transfer shapes. The lane count can be one, four or eight, and each lane setting can run at single or double transfer rate.

Every transaction starts with an 8-bit opcode and continues according to that opcode. A write opcode takes a 24-bit address followed by any number of data bytes. A read opcode takes a 24-bit address and a fixed number of dummy clocks, after which the block returns bytes that the array side places on `rd_byte_i`. The block drives the read bytes onto the correct lanes on the correct clock edges and enables only the drivers that the lane setting uses. Any other opcode is reported and the rest of that transaction is ignored.

Top module: `sflash_front`

## Requirements
- R1: While chip select is high (deselected), every output enable is 0 and no opcode, address or write-byte event is reported. A falling chip select starts a new transaction from the opcode phase.
- R2: The opcode is taken most significant bit first, one chunk per rising serial clock edge. A chunk is 1 bit on io[0] (lane code 00), 4 bits on io[3:0] (code 01) or 8 bits on io[7:0] (code 10). Falling edges are never used for the opcode, even when double rate is selected. `cmd_valid_o` pulses for one cycle with the value on `cmd_o`.
- R3: After opcode 0x02 or 0x0B, a 24-bit address is taken most significant chunk first. At single rate, chunks are captured on rising edges only. At double rate, they are captured on both edges, starting at the rising edge after the opcode's last clock cycle. `addr_valid_o` pulses when the address is complete.
- R4: After opcode 0x02 and its address, each further group of 8 bits is captured on the same edges and with the same chunking as the address, and is reported with a one-cycle `wr_valid_o` pulse.
- R5: After opcode 0x0B, its address and DUMMY_CYC further rising edges (8 by default), bytes taken from `rd_byte_i` are driven most significant chunk first. At single rate the output changes on falling edges; at double rate it changes on both edges, starting with the first falling edge after the dummy clocks. Lane code 00 uses io[1], 01 uses io[3:0] and 10 uses io[7:0]. `rd_next_o` pulses once for every byte taken.
- R6: Output enables are asserted only in the read data phase. The mask is 0x02, 0x0F or 0xFF for lane codes 00, 01 or 10, so io[7:4] are driven only in 8-lane mode.
- R7: A pause starts only when chip select and the serial clock are both low with hold low. During a pause, clock edges and input lines have no effect and all output enables are 0. After hold returns high, the transfer continues where it stopped.
- R8: Any opcode other than 0x02 and 0x0B produces no address, write-byte or read event, and no output enable, for the rest of the transaction.
- R9: Chip select rising in the middle of a field discards the partial field. The next transaction decodes from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select pin, low selects |
| sck_i | input | 1 | Serial clock pin |
| hold_n_i | input | 1 | Pause pin, low pauses |
| io_i | input | 8 | I/O pin input values |
| lanes_i | input | 2 | Lane code: 00 one, 01 four, 10 eight |
| dtr_i | input | 1 | 1 selects double transfer rate |
| rd_byte_i | input | 8 | Next read byte from the array side |
| io_o | output | 8 | I/O pin output values |
| io_oe_o | output | 8 | Per-pin output enable |
| cmd_valid_o | output | 1 | Opcode complete pulse |
| cmd_o | output | 8 | Last opcode |
| addr_valid_o | output | 1 | Address complete pulse |
| addr_o | output | ADDR_W | Last address |
| wr_valid_o | output | 1 | Write byte complete pulse |
| wr_byte_o | output | 8 | Last write byte |
| rd_next_o | output | 1 | Read byte consumed pulse |

## Verification
The assertions check several rules on every cycle. The drivers stay off once deselection has settled, and the state machine returns to idle after chip select rises. Address, write-byte and read-byte events appear only under the opcode that allows them. The upper four drivers turn on only in 8-lane mode. While a pause is active, neither the capture register nor the transmit register changes. Other behaviours can only be shown by the bench scenarios, which run every lane and rate combination. These include the bit order and edge choice of each field, the whole-cycle opcode at double rate, the dummy count and the first output edge, lane placement of read data, resuming after a pause, and discarding a field cut short by chip select.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_CTAIL,
    ST_ADDR,
    ST_DUMMY,
    ST_RDATA,
    ST_WDATA,
    ST_SKIP
  } sfe_st_e;

  localparam logic [1:0] LN_X1 = 2'b00;
  localparam logic [1:0] LN_X4 = 2'b01;
  localparam logic [1:0] LN_X8 = 2'b10;

  function automatic logic [3:0] lane_bits(input logic [1:0] ln);
    case (ln)
      LN_X4:   lane_bits = 4'd4;
      LN_X8:   lane_bits = 4'd8;
      default: lane_bits = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sfe_edge.sv
module sfe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic desel_s,
  input  logic hold_n_s,
  output logic rise,
  output logic fall,
  output logic held
);
  logic sck_d;
  logic held_d;

  // pause may only begin while selected and with the serial clock low
  always_comb held_d = !desel_s && !hold_n_s && (held || !sck_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      held  <= held_d;
    end
  end

  assign rise = sck_s && !sck_d && !held && !desel_s;
  assign fall = !sck_s && sck_d && !held && !desel_s;
endmodule

// File: rtl/sfe_core.sv
module sfe_core
  import sfe_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DUMMY_CYC = 8,
  parameter logic [7:0]  CMD_RD    = 8'h0B,
  parameter logic [7:0]  CMD_WR    = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desel_s,
  input  logic              held,
  input  logic              rise,
  input  logic              fall,
  input  logic [7:0]        io_s,
  input  logic [1:0]        lanes_i,
  input  logic              dtr_i,
  input  logic [7:0]        rd_byte_i,
  output logic [7:0]        io_o,
  output logic [7:0]        io_oe,
  output logic              cmd_v_q,
  output logic [7:0]        cmd_q,
  output logic              addr_v_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_v_q,
  output logic [7:0]        wrb_q,
  output logic              rdn_q
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam int DCW   = (DUMMY_CYC < 2) ? 1 : $clog2(DUMMY_CYC + 1);
  localparam logic [CNT_W-1:0] BYTE_C = CNT_W'(8);
  localparam logic [CNT_W-1:0] ADDR_C = CNT_W'(ADDR_W);
  localparam logic [DCW-1:0]   DLAST  = DCW'(DUMMY_CYC);

  sfe_st_e           st_q, st_d;
  logic [ADDR_W-1:0] sr_q, sr_d, sh;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_nx, widc;
  logic [DCW-1:0]    dcnt_q, dcnt_d;
  logic [7:0]        tx_q, tx_d;
  logic [3:0]        txl_q, txl_d, wid;
  logic [7:0]        cmd_d, wrb_d;
  logic [ADDR_W-1:0] addr_d;
  logic              cmd_v_d, addr_v_d, wr_v_d, rdn_d;
  logic              data_edge, out_edge, is_rd, is_wr;

  assign wid       = lane_bits(lanes_i);
  assign widc      = CNT_W'(wid);
  assign cnt_nx    = cnt_q + widc;
  assign data_edge = dtr_i ? (rise || fall) : rise;
  assign out_edge  = dtr_i ? (rise || fall) : fall;
  assign is_rd     = (cmd_q == CMD_RD);
  assign is_wr     = (cmd_q == CMD_WR);

  always_comb begin
    case (lanes_i)
      LN_X4:   sh = {sr_q[ADDR_W-5:0], io_s[3:0]};
      LN_X8:   sh = {sr_q[ADDR_W-9:0], io_s};
      default: sh = {sr_q[ADDR_W-2:0], io_s[0]};
    endcase
  end

  always_comb begin
    st_d = st_q;  sr_d = sr_q;  cnt_d = cnt_q;  dcnt_d = dcnt_q;
    tx_d = tx_q;  txl_d = txl_q;  cmd_d = cmd_q;  addr_d = addr_q;
    wrb_d = wrb_q;
    cmd_v_d = 1'b0;  addr_v_d = 1'b0;  wr_v_d = 1'b0;  rdn_d = 1'b0;
    if (desel_s) begin
      st_d = ST_IDLE;  cnt_d = '0;  dcnt_d = '0;  tx_d = '0;  txl_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d  = ST_CMD;
          cnt_d = '0;
        end
        ST_CMD: if (rise) begin
          sr_d  = sh;
          cnt_d = cnt_nx;
          if (cnt_nx == BYTE_C) begin
            cmd_d   = sh[7:0];
            cmd_v_d = 1'b1;
            st_d    = ST_CTAIL;
          end
        end
        // opcode occupies whole clock cycles: swallow the trailing fall
        ST_CTAIL: if (fall) begin
          cnt_d = '0;
          st_d  = (is_rd || is_wr) ? ST_ADDR : ST_SKIP;
        end
        ST_ADDR: if (data_edge) begin
          sr_d  = sh;
          cnt_d = cnt_nx;
          if (cnt_nx == ADDR_C) begin
            addr_d   = sh;
            addr_v_d = 1'b1;
            cnt_d    = '0;
            dcnt_d   = '0;
            if (is_wr)               st_d = ST_WDATA;
            else if (DUMMY_CYC == 0) st_d = ST_RDATA;
            else                     st_d = ST_DUMMY;
          end
        end
        ST_DUMMY: if (rise) begin
          dcnt_d = dcnt_q + 1'b1;
          if (dcnt_q + 1'b1 == DLAST) st_d = ST_RDATA;
        end
        ST_RDATA: if (out_edge) begin
          if (txl_q == 4'd0) begin
            tx_d  = rd_byte_i;
            txl_d = 4'd8 - wid;
            rdn_d = 1'b1;
          end else begin
            tx_d  = tx_q << wid;
            txl_d = txl_q - wid;
          end
        end
        ST_WDATA: if (data_edge) begin
          sr_d  = sh;
          cnt_d = cnt_nx;
          if (cnt_nx == BYTE_C) begin
            wrb_d  = sh[7:0];
            wr_v_d = 1'b1;
            cnt_d  = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  sr_q <= '0;  cnt_q <= '0;  dcnt_q <= '0;
      tx_q <= '0;  txl_q <= '0;  cmd_q <= '0;  addr_q <= '0;  wrb_q <= '0;
      cmd_v_q <= 1'b0;  addr_v_q <= 1'b0;  wr_v_q <= 1'b0;  rdn_q <= 1'b0;
    end else begin
      st_q <= st_d;  sr_q <= sr_d;  cnt_q <= cnt_d;  dcnt_q <= dcnt_d;
      tx_q <= tx_d;  txl_q <= txl_d;  cmd_q <= cmd_d;  addr_q <= addr_d;
      wrb_q <= wrb_d;
      cmd_v_q <= cmd_v_d;  addr_v_q <= addr_v_d;  wr_v_q <= wr_v_d;
      rdn_q <= rdn_d;
    end
  end

  always_comb begin
    io_oe = '0;
    io_o  = '0;
    case (lanes_i)
      LN_X4:   io_o = {4'b0, tx_q[7:4]};
      LN_X8:   io_o = tx_q;
      default: io_o = {6'b0, tx_q[7], 1'b0};
    endcase
    if (st_q == ST_RDATA && !held) begin
      case (lanes_i)
        LN_X4:   io_oe = 8'h0F;
        LN_X8:   io_oe = 8'hFF;
        default: io_oe = 8'h02;
      endcase
    end
  end

  p_quiet_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desel_s && $past(desel_s) |-> io_oe == 8'h00);
  p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v_q |=> !cmd_v_q);
  p_addr_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_v_q |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));
  p_wr_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_v_q |-> cmd_q == CMD_WR);
  p_rd_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdn_q |-> cmd_q == CMD_RD);
  p_upper_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|io_oe[7:4]) |-> lanes_i == LN_X8);
  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    held && !desel_s |=> $stable(sr_q) && $stable(tx_q));
  p_cs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    desel_s |=> st_q == ST_IDLE);
endmodule

// File: rtl/sflash_front.sv
module sflash_front #(
  parameter int         ADDR_W    = 24,
  parameter int         DUMMY_CYC = 8,
  parameter logic [7:0] CMD_RD    = 8'h0B,
  parameter logic [7:0] CMD_WR    = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              hold_n_i,
  input  logic [7:0]        io_i,
  input  logic [1:0]        lanes_i,
  input  logic              dtr_i,
  input  logic [7:0]        rd_byte_i,
  output logic [7:0]        io_o,
  output logic [7:0]        io_oe_o,
  output logic              cmd_valid_o,
  output logic [7:0]        cmd_o,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_valid_o,
  output logic [7:0]        wr_byte_o,
  output logic              rd_next_o
);
  localparam int SW = 11;
  localparam logic [SW-1:0] SYNC_RST = 11'b110_0000_0000;

  logic [SW-1:0] pins_s;
  logic          rise, fall, held;

  sfe_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({cs_n_i, hold_n_i, sck_i, io_i}),
    .q (pins_s)
  );

  sfe_edge u_edge (
    .clk (clk),
    .rst_n (rst_n),
    .sck_s (pins_s[8]),
    .desel_s (pins_s[10]),
    .hold_n_s (pins_s[9]),
    .rise (rise),
    .fall (fall),
    .held (held)
  );

  sfe_core #(
    .ADDR_W (ADDR_W),
    .DUMMY_CYC (DUMMY_CYC),
    .CMD_RD (CMD_RD),
    .CMD_WR (CMD_WR)
  ) u_core (
    .clk (clk),
    .rst_n (rst_n),
    .desel_s (pins_s[10]),
    .held (held),
    .rise (rise),
    .fall (fall),
    .io_s (pins_s[7:0]),
    .lanes_i (lanes_i),
    .dtr_i (dtr_i),
    .rd_byte_i (rd_byte_i),
    .io_o (io_o),
    .io_oe (io_oe_o),
    .cmd_v_q (cmd_valid_o),
    .cmd_q (cmd_o),
    .addr_v_q (addr_valid_o),
    .addr_q (addr_o),
    .wr_v_q (wr_valid_o),
    .wrb_q (wr_byte_o),
    .rdn_q (rd_next_o)
  );
endmodule

// File: tb/test_sflash_front.sv
module test_sflash_front;
  localparam int DUMMY = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cs_n, sck, hold_n, dtr;
  logic [7:0]  io_drv, rd_byte, io_o, io_oe, cmd, wr_byte;
  logic [1:0]  lanes;
  logic        cmd_v, addr_v, wr_v, rd_next;
  logic [23:0] addr;

  sflash_front i_sflash_front (
    .clk (clk), .rst_n (rst_n), .cs_n_i (cs_n), .sck_i (sck),
    .hold_n_i (hold_n), .io_i (io_drv), .lanes_i (lanes), .dtr_i (dtr),
    .rd_byte_i (rd_byte), .io_o (io_o), .io_oe_o (io_oe),
    .cmd_valid_o (cmd_v), .cmd_o (cmd), .addr_valid_o (addr_v),
    .addr_o (addr), .wr_valid_o (wr_v), .wr_byte_o (wr_byte),
    .rd_next_o (rd_next)
  );

  int checks = 0;
  int fails  = 0;
  int exp_k[$];
  int exp_v[$];
  int rd_cnt;
  int rc0;
  logic [7:0] f0;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // array-side feeder: a new byte after every consumed one
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_byte <= 8'h30;
      rd_cnt  <= 0;
    end else if (rd_next) begin
      rd_byte <= rd_byte + 8'h01;
      rd_cnt  <= rd_cnt + 1;
    end
  end

  function automatic void ev(int k, int v);
    int ek, evv;
    if (exp_k.size() == 0) begin
      chk(0, "R8", "unexpected event kind", k, -1);
    end else begin
      ek  = exp_k.pop_front();
      evv = exp_v.pop_front();
      chk(k == ek, "R1", "event kind", k, ek);
      if (k == 0) chk(v == evv, "R2", "opcode", v, evv);
      if (k == 1) chk(v == evv, "R3", "address", v, evv);
      if (k == 2) chk(v == evv, "R4", "write byte", v, evv);
    end
  endfunction

  // reference event model compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_v)  ev(0, int'(cmd));
      if (addr_v) ev(1, int'(addr));
      if (wr_v)   ev(2, int'(wr_byte));
    end
  end

  function automatic int wdt();
    return (lanes == 2'b01) ? 4 : (lanes == 2'b10) ? 8 : 1;
  endfunction

  function automatic logic [7:0] place(int c);
    case (wdt())
      4:       return {4'hF, c[3:0]};
      8:       return c[7:0];
      default: return {7'h7F, c[0]};
    endcase
  endfunction

  function automatic logic [7:0] omask();
    return (wdt() == 4) ? 8'h0F : (wdt() == 8) ? 8'hFF : 8'h02;
  endfunction

  function automatic logic [7:0] oval(int c);
    case (wdt())
      4:       return {4'h0, c[3:0]};
      8:       return c[7:0];
      default: return {6'b0, c[0], 1'b0};
    endcase
  endfunction

  task automatic tog(input logic [7:0] d);
    io_drv = d;
    repeat (5) @(negedge clk);
    sck = ~sck;
    repeat (5) @(negedge clk);
  endtask

  task automatic send(input int val, input int nbits, input bit two);
    int w = wdt();
    for (int i = 0; i < nbits / w; i++) begin
      int c = (val >> (nbits - w * (i + 1))) & ((1 << w) - 1);
      tog(place(c));
      if (!two) tog(place(c));
    end
  endtask

  task automatic begin_t(input logic [1:0] l, input logic d);
    lanes = l;
    dtr   = d;
    cs_n  = 1'b0;
    repeat (6) @(negedge clk);
    f0  = rd_byte;
    rc0 = rd_cnt;
  endtask

  task automatic end_t();
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    sck = 1'b0;
    repeat (6) @(negedge clk);
    chk(io_oe == 8'h00, "R1", "oe while deselected", io_oe, 0);
    chk(exp_k.size() == 0, "R1", "missing events", exp_k.size(), 0);
    exp_k.delete();
    exp_v.delete();
  endtask

  task automatic push(input int k, input int v);
    exp_k.push_back(k);
    exp_v.push_back(v);
  endtask

  task automatic do_hold();
    hold_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(io_oe == 8'h00, "R7", "oe during pause", io_oe, 0);
    tog(8'h00);
    tog(8'h55);
    hold_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic sample(input int k, input int j);
    int w = wdt();
    logic [7:0] b = f0 + 8'(k);
    int c = (int'(b) >> (8 - w * (j + 1))) & ((1 << w) - 1);
    chk((io_o & omask()) == oval(c), "R5", "read chunk", io_o & omask(), oval(c));
    chk(io_oe == omask(), "R6", "oe mask", io_oe, omask());
  endtask

  task automatic rd_txn(input logic [1:0] l, input logic d, input int a,
                        input int n, input int hold_at);
    int idx = 0;
    begin_t(l, d);
    push(0, 8'h0B); send(8'h0B, 8, 0);
    push(1, a);     send(a, 24, d);
    repeat (DUMMY) begin
      if (sck) tog(8'hFF);
      tog(8'hFF);
    end
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8 / wdt(); j++) begin
        tog(8'hFF);
        sample(k, j);
        if (idx == hold_at) do_hold();
        if (!d) tog(8'hFF);
        idx++;
      end
    end
    chk(rd_cnt - rc0 == n, "R5", "bytes consumed", rd_cnt - rc0, n);
    end_t();
  endtask

  task automatic wr_txn(input logic [1:0] l, input logic d, input int a, input int n);
    begin_t(l, d);
    push(0, 8'h02); send(8'h02, 8, 0);
    push(1, a);     send(a, 24, d);
    for (int i = 0; i < n; i++) begin
      int b = (a + i * 37) & 8'hFF;
      push(2, b);
      send(b, 8, d);
    end
    end_t();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; hold_n = 1'b1;
    io_drv = 8'h00; lanes = 2'b00; dtr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(io_oe == 8'h00, "R1", "reset oe", io_oe, 0);
    chk(cmd_v == 1'b0, "R1", "reset cmd pulse", cmd_v, 0);

    // every lane count at both rates
    for (int l = 0; l < 3; l++) begin
      for (int d = 0; d < 2; d++) begin
        wr_txn(2'(l), 1'(d), 24'h5A0000 + l * 24'h111 + d, 3);
        rd_txn(2'(l), 1'(d), 24'hC3A500 + l * 24'h10 + d, 2, -1);
      end
    end

    // R7: pause in the middle of an address and of read data
    begin_t(2'b00, 1'b0);
    push(0, 8'h02); send(8'h02, 8, 0);
    push(1, 24'hABCDEF);
    send(24'hABC, 12, 0);
    do_hold();
    send(24'hDEF, 12, 0);
    push(2, 8'h96); send(8'h96, 8, 0);
    end_t();
    rd_txn(2'b01, 1'b0, 24'h012345, 2, 1);

    // R8: unknown opcode leaves nothing behind
    begin_t(2'b01, 1'b0);
    push(0, 8'h9F); send(8'h9F, 8, 0);
    send(24'h123456, 24, 0);
    chk(io_oe == 8'h00, "R8", "oe after unknown opcode", io_oe, 0);
    send(24'h00FF00, 24, 0);
    chk(io_oe == 8'h00, "R8", "oe after more clocks", io_oe, 0);
    end_t();

    // R9: address cut short, then a clean transaction
    begin_t(2'b00, 1'b0);
    push(0, 8'h02); send(8'h02, 8, 0);
    send(24'h3FF, 10, 0);
    end_t();
    wr_txn(2'b10, 1'b1, 24'h00F00D, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule